// File: doc/BRIEF.md
# Fuse Array Access Controller

This block sits between a simple register bus and a one-time-programmable fuse macro. Software loads a fuse address, an optional write-unlock key and a set of cycle counts, then either triggers a sense of one fuse word or writes a data word that is burned into the addressed word. The controller produces the macro's read and program strobes with the requested setup, strobe and hold widths. It holds the address and program data steady for the whole operation and captures the sensed word into a data register.

The bus is a single-cycle write port plus a combinational read port selected by a 3-bit register index: 0 control, 1 control clear alias, 2 timing, 3 sense trigger, 4 program data, 5 sense data. Other indices read as zero. Burning is guarded by a 16-bit key that has to be rewritten before every program operation. Misuse sets a sticky error flag, which software clears through the alias register.

Top module: `fuse_access_ctrl`

## Requirements
- R1: After reset the control register reads 0 (key, error, busy and address all clear), the sense-data register reads 0 and the timing register reads 0x003FFFFF (all counts at their maximum).
- R2: The control register (index 0) holds the key in bits 31:16, the error flag in bit 9 (read-only), busy in bit 8 (read-only) and the fuse address in bits 6:0, where bits 6:3 pick the bank and bits 2:0 the word. The address is driven on fz_addr and does not change while busy.
- R3: The timing register (index 2) holds the read-strobe count in bits 21:16, the relax count in bits 15:12 and the program-strobe count in bits 11:0. All other bits read as 0.
- R4: Writing a word with bit 0 set to index 3 while idle starts a sense. The word returned by the macro during the strobe is in the sense-data register (index 5) by the time busy falls, and it stays unchanged through program operations. A write with bit 0 clear does nothing.
- R5: Each operation with relax count r and strobe count c has r+1 setup cycles, a strobe c+1-2(r+1) cycles wide (at least 1) and r+1 hold cycles. Busy is high for the whole of it.
- R6: Writing index 4 while idle with key 0x3E77 in the control register starts a program operation. fz_pg_stb is timed by the program-strobe count, and fz_wdata carries the written word throughout.
- R7: Writing index 4 with any other key produces no strobe and sets the error flag.
- R8: The error flag stays set until a write to index 1 with bit 9 set. Writes to index 1 with bit 9 clear leave it set.
- R9: A sense trigger or program-data write that arrives while busy starts nothing. The key and the running operation are left unchanged, and the error flag is set.
- R10: When a program operation completes, the key field returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_idx | input | 3 | Register index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_idx (combinational) |
| fz_addr | output | 7 | Fuse word address to the macro |
| fz_rd_stb | output | 1 | Macro sense strobe |
| fz_pg_stb | output | 1 | Macro program strobe |
| fz_wdata | output | 32 | Data word to burn |
| fz_rdata | input | 32 | Word returned by the macro |

## Verification
The in-line assertions check the following on every cycle: the error flag stays sticky, a rejected or colliding write sets the error, the key clears after a program, the address holds while busy, a hold phase follows every strobe, and the sense data stays unchanged during programming. Only the bench scenarios can show the exact setup, strobe and busy lengths across several timing settings, including the width-1 clamp. The same holds for the absence of any strobe after a bad key or a collision, and for the register layouts. They also show that a sense after two programs returns the OR of both words from the bench's fuse model.

// File: rtl/fuse_ctrl_pkg.sv
// Shared definitions for the fuse access controller.
// Assumes a 3-bit register index on the bus side.
package fuse_ctrl_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_SETUP  = 2'd1,
        SQ_STROBE = 2'd2,
        SQ_HOLD   = 2'd3
    } seq_state_t;

    localparam logic [2:0] RG_CTRL      = 3'd0;
    localparam logic [2:0] RG_CTRL_CLR  = 3'd1;
    localparam logic [2:0] RG_TIMING    = 3'd2;
    localparam logic [2:0] RG_RD_TRIG   = 3'd3;
    localparam logic [2:0] RG_PROG_DATA = 3'd4;
    localparam logic [2:0] RG_SENSE     = 3'd5;

    localparam int KEY_LSB  = 16;
    localparam int ERR_BIT  = 9;
    localparam int BUSY_BIT = 8;

endpackage

// File: rtl/fuse_regfile.sv
// Register file of the fuse controller: control, timing and program-data
// registers, start and error decisions. Assumes the sequencer reports
// busy and a one-cycle pg_done at the end of a program operation.
module fuse_regfile
    import fuse_ctrl_pkg::*;
#(
    parameter int ADDR_W  = 7,
    parameter int DATA_W  = 32,
    parameter int RELAX_W = 4,
    parameter int RSTB_W  = 6,
    parameter int PSTB_W  = 12,
    parameter int KEY_W   = 16,
    parameter logic [KEY_W-1:0] KEY_VAL = 16'h3E77
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [2:0]        bus_idx,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              busy,
    input  logic              pg_done,
    input  logic [DATA_W-1:0] sense_data,
    output logic              start_rd,
    output logic              start_pg,
    output logic [ADDR_W-1:0] cfg_addr,
    output logic [RELAX_W-1:0] cfg_relax,
    output logic [RSTB_W-1:0] cfg_rstb,
    output logic [PSTB_W-1:0] cfg_pstb,
    output logic [DATA_W-1:0] prog_word
);

    localparam int RELAX_LSB = PSTB_W;
    localparam int RSTB_LSB  = PSTB_W + RELAX_W;

    logic [KEY_W-1:0]   key_q;
    logic [ADDR_W-1:0]  addr_q;
    logic               err_q;
    logic [RELAX_W-1:0] relax_q;
    logic [RSTB_W-1:0]  rstb_q;
    logic [PSTB_W-1:0]  pstb_q;
    logic [DATA_W-1:0]  pdata_q;

    logic wr_ctrl, wr_clr, wr_tim, wr_trig, wr_pdat, key_ok, err_set;

    // Decode bus writes and decide whether an operation may start.
    always_comb begin
        wr_ctrl  = bus_wr && (bus_idx == RG_CTRL);
        wr_clr   = bus_wr && (bus_idx == RG_CTRL_CLR);
        wr_tim   = bus_wr && (bus_idx == RG_TIMING);
        wr_trig  = bus_wr && (bus_idx == RG_RD_TRIG) && bus_wdata[0];
        wr_pdat  = bus_wr && (bus_idx == RG_PROG_DATA);
        key_ok   = (key_q == KEY_VAL);
        start_rd = wr_trig && !busy;
        start_pg = wr_pdat && !busy && key_ok;
        err_set  = ((wr_trig || wr_pdat) && busy) || (wr_pdat && !busy && !key_ok);
    end

    // Control fields: key and address; key clears when a program ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_q  <= '0;
            addr_q <= '0;
        end else if (wr_ctrl) begin
            key_q  <= bus_wdata[KEY_LSB +: KEY_W];
            addr_q <= bus_wdata[ADDR_W-1:0];
        end else if (pg_done) begin
            key_q  <= '0;
        end
    end

    // Sticky error flag; a new error wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_q <= 1'b0;
        else if (err_set)
            err_q <= 1'b1;
        else if (wr_clr && bus_wdata[ERR_BIT])
            err_q <= 1'b0;
    end

    // Timing counts, reset to their largest values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            relax_q <= '1;
            rstb_q  <= '1;
            pstb_q  <= '1;
        end else if (wr_tim) begin
            relax_q <= bus_wdata[RELAX_LSB +: RELAX_W];
            rstb_q  <= bus_wdata[RSTB_LSB +: RSTB_W];
            pstb_q  <= bus_wdata[PSTB_W-1:0];
        end
    end

    // Program data, captured only when a program operation is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pdata_q <= '0;
        else if (start_pg)
            pdata_q <= bus_wdata;
    end

    // Combinational read-back of the selected register.
    always_comb begin
        bus_rdata = '0;
        case (bus_idx)
            RG_CTRL, RG_CTRL_CLR: begin
                bus_rdata[KEY_LSB +: KEY_W] = key_q;
                bus_rdata[ERR_BIT]          = err_q;
                bus_rdata[BUSY_BIT]         = busy;
                bus_rdata[ADDR_W-1:0]       = addr_q;
            end
            RG_TIMING: begin
                bus_rdata[RSTB_LSB +: RSTB_W]   = rstb_q;
                bus_rdata[RELAX_LSB +: RELAX_W] = relax_q;
                bus_rdata[PSTB_W-1:0]           = pstb_q;
            end
            RG_SENSE: bus_rdata = sense_data;
            default:  bus_rdata = '0;
        endcase
    end

    assign cfg_addr  = addr_q;
    assign cfg_relax = relax_q;
    assign cfg_rstb  = rstb_q;
    assign cfg_pstb  = pstb_q;
    assign prog_word = pdata_q;

    // R8: the error flag only drops through the clear alias.
    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !(wr_clr && bus_wdata[ERR_BIT])) |=> err_q)
        else $error("error flag dropped without a clear");

    // R7: a program-data write without the key leaves the error set.
    assert_badkey_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pdat && (key_q != KEY_VAL)) |=> err_q)
        else $error("bad key did not raise error");

    // R9: a trigger or data write while busy leaves the error set.
    assert_busy_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_trig || wr_pdat) && busy) |=> err_q)
        else $error("access while busy did not raise error");

    // R10: key field is zero after a program completes.
    assert_key_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pg_done && !wr_ctrl) |=> (key_q == '0))
        else $error("key not cleared after program");

endmodule

// File: rtl/fuse_seq.sv
// Operation sequencer: setup, strobe and hold phases for a sense or a
// program. Assumes starts arrive only while idle (gated by the register
// file) and that counts are stable in the start cycle.
module fuse_seq
    import fuse_ctrl_pkg::*;
#(
    parameter int ADDR_W  = 7,
    parameter int DATA_W  = 32,
    parameter int RELAX_W = 4,
    parameter int RSTB_W  = 6,
    parameter int PSTB_W  = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_rd,
    input  logic               start_pg,
    input  logic [ADDR_W-1:0]  cfg_addr,
    input  logic [RELAX_W-1:0] cfg_relax,
    input  logic [RSTB_W-1:0]  cfg_rstb,
    input  logic [PSTB_W-1:0]  cfg_pstb,
    input  logic [DATA_W-1:0]  fz_rdata,
    output logic               busy,
    output logic               pg_done,
    output logic [DATA_W-1:0]  sense_data,
    output logic [ADDR_W-1:0]  fz_addr,
    output logic               fz_rd_stb,
    output logic               fz_pg_stb
);

    localparam int LEN_W = (PSTB_W > RSTB_W) ? PSTB_W : RSTB_W;
    localparam int CNT_W = ((LEN_W > RELAX_W + 1) ? LEN_W : RELAX_W + 1) + 2;

    seq_state_t         st_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [CNT_W-1:0]   len_q;
    logic [RELAX_W-1:0] relax_q;
    logic [ADDR_W-1:0]  addr_q;
    logic               is_pg_q;
    logic [DATA_W-1:0]  sense_q;

    logic [CNT_W-1:0] total, edge_len, stb_len;

    // Strobe width for the operation being started, never below one.
    always_comb begin
        total    = (start_pg ? CNT_W'(cfg_pstb) : CNT_W'(cfg_rstb)) + CNT_W'(1);
        edge_len = (CNT_W'(cfg_relax) + CNT_W'(1)) << 1;
        stb_len  = (total > edge_len) ? (total - edge_len) : CNT_W'(1);
    end

    // Phase state machine with one down-counter shared by all phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= SQ_IDLE;
            cnt_q   <= '0;
            len_q   <= '0;
            relax_q <= '0;
            addr_q  <= '0;
            is_pg_q <= 1'b0;
        end else begin
            case (st_q)
                SQ_IDLE: if (start_rd || start_pg) begin
                    st_q    <= SQ_SETUP;
                    cnt_q   <= CNT_W'(cfg_relax);
                    len_q   <= stb_len;
                    relax_q <= cfg_relax;
                    addr_q  <= cfg_addr;
                    is_pg_q <= start_pg;
                end
                SQ_SETUP: if (cnt_q == '0) begin
                    st_q  <= SQ_STROBE;
                    cnt_q <= len_q - CNT_W'(1);
                end else begin
                    cnt_q <= cnt_q - CNT_W'(1);
                end
                SQ_STROBE: if (cnt_q == '0) begin
                    st_q  <= SQ_HOLD;
                    cnt_q <= CNT_W'(relax_q);
                end else begin
                    cnt_q <= cnt_q - CNT_W'(1);
                end
                SQ_HOLD: if (cnt_q == '0) begin
                    st_q <= SQ_IDLE;
                end else begin
                    cnt_q <= cnt_q - CNT_W'(1);
                end
                default: st_q <= SQ_IDLE;
            endcase
        end
    end

    // Capture the sensed word in the last strobe cycle of a sense.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sense_q <= '0;
        else if (st_q == SQ_STROBE && cnt_q == '0 && !is_pg_q)
            sense_q <= fz_rdata;
    end

    assign busy       = (st_q != SQ_IDLE);
    assign pg_done    = (st_q == SQ_HOLD) && (cnt_q == '0) && is_pg_q;
    assign fz_rd_stb  = (st_q == SQ_STROBE) && !is_pg_q;
    assign fz_pg_stb  = (st_q == SQ_STROBE) && is_pg_q;
    assign fz_addr    = addr_q;
    assign sense_data = sense_q;

    // R2: the macro address holds for the whole operation.
    assert_addr_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(fz_addr))
        else $error("fuse address moved while busy");

    // R5: a hold phase always follows the end of a strobe.
    assert_hold_after_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(fz_rd_stb) || $fell(fz_pg_stb)) |-> busy)
        else $error("no hold phase after strobe");

    // R4: programming never disturbs the sense-data register.
    assert_sense_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fz_pg_stb |=> $stable(sense_data))
        else $error("sense data changed during program");

endmodule

// File: rtl/fuse_access_ctrl.sv
// Top of the fuse access controller: register file plus sequencer.
// Assumes a behavioural or real fuse macro that burns fz_wdata into
// fz_addr while fz_pg_stb is high and returns the word on fz_rdata
// while fz_rd_stb is high.
module fuse_access_ctrl #(
    parameter int ADDR_W  = 7,
    parameter int DATA_W  = 32,
    parameter int RELAX_W = 4,
    parameter int RSTB_W  = 6,
    parameter int PSTB_W  = 12,
    parameter int KEY_W   = 16,
    parameter logic [KEY_W-1:0] KEY_VAL = 16'h3E77
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [2:0]        bus_idx,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [ADDR_W-1:0] fz_addr,
    output logic              fz_rd_stb,
    output logic              fz_pg_stb,
    output logic [DATA_W-1:0] fz_wdata,
    input  logic [DATA_W-1:0] fz_rdata
);

    logic               busy, pg_done, start_rd, start_pg;
    logic [DATA_W-1:0]  sense_data;
    logic [ADDR_W-1:0]  cfg_addr;
    logic [RELAX_W-1:0] cfg_relax;
    logic [RSTB_W-1:0]  cfg_rstb;
    logic [PSTB_W-1:0]  cfg_pstb;

    fuse_regfile #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RELAX_W(RELAX_W),
        .RSTB_W(RSTB_W), .PSTB_W(PSTB_W), .KEY_W(KEY_W), .KEY_VAL(KEY_VAL)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_idx(bus_idx), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .busy(busy), .pg_done(pg_done), .sense_data(sense_data),
        .start_rd(start_rd), .start_pg(start_pg),
        .cfg_addr(cfg_addr), .cfg_relax(cfg_relax),
        .cfg_rstb(cfg_rstb), .cfg_pstb(cfg_pstb),
        .prog_word(fz_wdata)
    );

    fuse_seq #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RELAX_W(RELAX_W),
        .RSTB_W(RSTB_W), .PSTB_W(PSTB_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .start_rd(start_rd), .start_pg(start_pg),
        .cfg_addr(cfg_addr), .cfg_relax(cfg_relax),
        .cfg_rstb(cfg_rstb), .cfg_pstb(cfg_pstb),
        .fz_rdata(fz_rdata),
        .busy(busy), .pg_done(pg_done), .sense_data(sense_data),
        .fz_addr(fz_addr), .fz_rd_stb(fz_rd_stb), .fz_pg_stb(fz_pg_stb)
    );

endmodule

// File: tb/tb_fuse_access_ctrl.sv
// Scoreboard bench: driver tasks push expected strobe events, a monitor
// measures every strobe on the macro pins and compares against the queue.
module tb_fuse_access_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_idx = 3'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic [6:0]  fz_addr;
    logic        fz_rd_stb, fz_pg_stb;
    logic [31:0] fz_wdata, fz_rdata;

    always #4 clk = ~clk;

    fuse_access_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_idx(bus_idx),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fz_addr(fz_addr),
        .fz_rd_stb(fz_rd_stb), .fz_pg_stb(fz_pg_stb), .fz_wdata(fz_wdata),
        .fz_rdata(fz_rdata)
    );

    // Behavioural fuse macro: program ORs bits in, sense returns the word.
    logic [31:0] fuse_mem [128];
    initial for (int i = 0; i < 128; i++) fuse_mem[i] = 32'd0;
    always @(posedge clk) if (fz_pg_stb) fuse_mem[fz_addr] <= fuse_mem[fz_addr] | fz_wdata;
    assign fz_rdata = fz_rd_stb ? fuse_mem[fz_addr] : 32'h0BAD0BAD;

    typedef struct {
        int          req;
        bit          pg;
        logic [6:0]  addr;
        logic [31:0] data;
        int          setup;
        int          width;
    } op_t;
    op_t exp_q[$];

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    task automatic chk(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d %s actual=0x%08h expected=0x%08h", req, what, act, exp);
        end
    endtask

    function automatic int slen(input int cnt, input int r);
        return (cnt + 1 > 2 * (r + 1)) ? cnt + 1 - 2 * (r + 1) : 1;
    endfunction

    // Monitor: measures setup gap, strobe width, address and data.
    int gap = 0, width = 0, m_setup = 0;
    bit in_stb = 0, m_pg = 0;
    logic [6:0]  m_addr;
    logic [31:0] m_data;
    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            if (fz_rd_stb || fz_pg_stb) begin
                if (!in_stb) begin
                    in_stb = 1; width = 0; m_setup = gap;
                    m_pg = fz_pg_stb; m_addr = fz_addr; m_data = fz_wdata;
                end
                width++;
            end else begin
                if (in_stb) begin
                    in_stb = 0;
                    if (exp_q.size() == 0) begin
                        checks++; fails++;
                        $display("FAIL R7/R9 unexpected strobe actual=pg%0d@0x%02h expected=none", m_pg, m_addr);
                    end else begin
                        op_t e;
                        e = exp_q.pop_front();
                        chk(e.req, "strobe kind", 32'(m_pg), 32'(e.pg));
                        chk(2, "strobe address", 32'(m_addr), 32'(e.addr));
                        chk(5, "setup cycles", m_setup, e.setup);
                        chk(5, "strobe width", width, e.width);
                        if (e.pg) chk(6, "program data", m_data, e.data);
                    end
                end
                gap++;
            end
            if (bus_wr && (bus_idx == 3'd3 || bus_idx == 3'd4)) gap = 0;
        end
    end

    task automatic bwr(input logic [2:0] idx, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_idx = idx; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic brd(input logic [2:0] idx, output logic [31:0] d);
        bus_idx = idx;
        #1;
        d = bus_rdata;
    endtask

    task automatic push(input int req, input bit pg, input logic [6:0] a, input logic [31:0] d,
                        input int su, input int w);
        op_t e;
        e.req = req; e.pg = pg; e.addr = a; e.data = d; e.setup = su; e.width = w;
        exp_q.push_back(e);
    endtask

    // Count cycles with busy set, starting at the negedge after the start.
    task automatic count_busy(output int n);
        logic [31:0] v;
        n = 0;
        for (int k = 0; k < 20000; k++) begin
            brd(3'd0, v);
            if (!v[8]) break;
            n++;
            @(negedge clk);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1; checks++; fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        brd(3'd0, v); chk(1, "ctrl after reset", v, 32'h0);
        brd(3'd2, v); chk(1, "timing after reset", v, 32'h003FFFFF);
        brd(3'd5, v); chk(1, "sense after reset", v, 32'h0);

        // R3: timing layout, relax=1 read=7 prog=11; stray bits dropped
        bwr(3'd2, 32'hFFC7_100B);
        brd(3'd2, v); chk(3, "timing readback", v, 32'h0007_100B);

        // R2: address bank 5 word 3; busy/error bits not writable
        bwr(3'd0, 32'h0000_032B);
        brd(3'd0, v); chk(2, "ctrl readback", v, 32'h0000_002B);

        // R7: program-data write without key
        bwr(3'd4, 32'h0000_00F0);
        idle(40);
        brd(3'd0, v); chk(7, "error after bad key", v, 32'h0000_022B);

        // R8: clear alias needs bit 9
        bwr(3'd1, 32'hFFFF_FDFF);
        brd(3'd0, v); chk(8, "error kept", v, 32'h0000_022B);
        bwr(3'd1, 32'h0000_0200);
        brd(3'd0, v); chk(8, "error cleared", v, 32'h0000_002B);

        // R6: first program with key
        bwr(3'd0, 32'h3E77_002B);
        push(6, 1, 7'h2B, 32'h0000_00F0, 2, slen(11, 1));
        bwr(3'd4, 32'h0000_00F0);
        count_busy(n); chk(5, "program busy cycles", n, 12);
        brd(3'd0, v); chk(10, "key cleared after program", v, 32'h0000_002B);

        // R10: fresh key, second program
        bwr(3'd0, 32'h3E77_002B);
        push(6, 1, 7'h2B, 32'h0F00_0001, 2, slen(11, 1));
        bwr(3'd4, 32'h0F00_0001);
        count_busy(n); chk(6, "second program busy", n, 12);

        // R4: sense returns OR of both programs
        push(4, 0, 7'h2B, 32'h0, 2, slen(7, 1));
        bwr(3'd3, 32'h0000_0001);
        count_busy(n); chk(4, "sense busy cycles", n, 8);
        brd(3'd5, v); chk(4, "sensed word", v, 32'h0F00_00F1);
        brd(3'd0, v); chk(4, "no error after sense", v, 32'h0000_002B);

        // R4: trigger with bit 0 clear does nothing
        bwr(3'd3, 32'hFFFF_FFFE);
        idle(20);
        brd(3'd0, v); chk(4, "no op on bit0 clear", v, 32'h0000_002B);

        // R2: top address bank 15 word 7
        bwr(3'd0, 32'h0000_007F);
        push(2, 0, 7'h7F, 32'h0, 2, slen(7, 1));
        bwr(3'd3, 32'h0000_0001);
        count_busy(n);
        brd(3'd5, v); chk(2, "blank word sensed", v, 32'h0);

        // R9: program-data write one cycle into a sense is rejected
        bwr(3'd0, 32'h3E77_0011);
        push(9, 0, 7'h11, 32'h0, 0, slen(7, 1));
        bwr(3'd3, 32'h0000_0001);
        bwr(3'd4, 32'hFFFF_FFFF);
        count_busy(n);
        idle(4);
        brd(3'd0, v); chk(9, "collision sets error, key kept", v, 32'h3E77_0211);
        brd(3'd5, v); chk(9, "sense of unburned word", v, 32'h0);

        // R5: clamp to a one-cycle strobe with relax 0, read count 0
        bwr(3'd1, 32'h0000_0200);
        bwr(3'd0, 32'h0000_002B);
        bwr(3'd2, 32'h0000_0000);
        push(5, 0, 7'h2B, 32'h0, 1, 1);
        bwr(3'd3, 32'h0000_0001);
        count_busy(n); chk(5, "clamped busy cycles", n, 3);
        brd(3'd5, v); chk(4, "sensed after clamp", v, 32'h0F00_00F1);

        // R5: relax 3, read count 20, program count 30
        bwr(3'd2, 32'h0014_301E);
        bwr(3'd0, 32'h3E77_002B);
        push(6, 1, 7'h2B, 32'h0000_0100, 4, slen(30, 3));
        bwr(3'd4, 32'h0000_0100);
        count_busy(n); chk(5, "long program busy", n, 31);
        push(4, 0, 7'h2B, 32'h0, 4, slen(20, 3));
        bwr(3'd3, 32'h0000_0001);
        count_busy(n); chk(5, "long sense busy", n, 21);
        brd(3'd5, v); chk(4, "sensed after third program", v, 32'h0F00_01F1);

        idle(5);
        chk(6, "all expected strobes seen", exp_q.size(), 0);

        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule